// File: doc/BRIEF.md
# Asymmetric SCL Phase Timer

This block sets the timing of the serial clock for a two-wire bus master. It runs from a fast core clock. It decides when the master pulls SCL low and when it lets the line go. The high phase comes from a 12-bit divider n. Software supplies n as two separate fields, a 10-bit low part and a 2-bit high part. A fixed latency of 15 core clocks, which covers input synchronisation and filtering, is added to n. The low phase has two sources. An enable bit can give it its own 12-bit count m, and then it lasts twice m. When that bit is clear, the low phase reuses the high-phase count, and the clock is symmetric.

The bit engine next to this block receives three one-cycle ticks. One marks the start of the low drive, one marks the release, and one marks the mid-high point where SDA should be captured. The SCL line is read back through a synchroniser. After a release, the high-phase counter does not run until the line is actually seen high. A slave that holds SCL low therefore lengthens the low part of the bus period without shortening the high part. Each counter takes its divider fields when its phase begins.

Top module: `scl_period_gen`

## Requirements
- R1: While reset is active, and while run_i has stayed low since reset, scl_drive_low_o is 0 and all three ticks are 0.
- R2: The high divider is n = ctrl_div_hi_i·1024 + ctrl_div_lo_i. ctrl_div_hi_i supplies bits 11:10 of n and ctrl_div_lo_i supplies bits 9:0.
- R3: With no stretching, SCL stays released for n + 15 core clocks, counted from the clock edge that clears scl_drive_low_o to the edge that sets it again.
- R4: scl_drive_low_o is held for 2·m core clocks when addr_low_en_i is 1, where m = addr_low_div_i. When addr_low_en_i is 0 it is held for n + 15 core clocks, and m has no effect.
- R5: A divider value of 0, for either n or m, behaves exactly as a value of 1.
- R6: While SCL reads low after a release, the block does not drive it. The next low drive begins n + 14 cycles after the first rising clock edge at which scl_i is high. The low-drive length itself is unchanged by the stretch.
- R7: Each phase takes its divider values at the edge where it begins. A field change during a low phase leaves that low phase unchanged, and the following high phase and later phases use the new value.
- R8: tick_fall_o is 1 for exactly the first cycle of each low drive. tick_rise_o is 1 for exactly the first cycle after each release.
- R9: tick_sample_o pulses exactly once per high phase. Each pulse comes while SCL is released and reads high.
- R10: If run_i falls during a low drive, that low phase and the following high phase complete. After that, SCL stays released and no further tick_fall_o occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Keep generating SCL periods |
| ctrl_div_lo_i | input | 10 | High divider n, bits 9:0 |
| ctrl_div_hi_i | input | 2 | High divider n, bits 11:10 |
| addr_low_div_i | input | 12 | Low divider m |
| addr_low_en_i | input | 1 | 1: low phase is 2·m; 0: low phase matches the high phase |
| scl_i | input | 1 | SCL line as seen at the pad |
| scl_drive_low_o | output | 1 | 1 pulls SCL low; 0 releases it |
| tick_fall_o | output | 1 | First cycle of a low drive |
| tick_rise_o | output | 1 | First cycle after a release |
| tick_sample_o | output | 1 | Mid-high SDA capture point |

## Verification
The bench builds the block with its default values: a filter latency of 15 and a two-stage synchroniser. With these values the counted part of the high phase is n + 12, so every expected phase length follows directly from n and m. The small dividers keep most periods within a few dozen cycles. That leaves room in the run for a divider with bit 10 set, a full-scale n and m pair, and a slave stretch of several cycles, so the split field, the doubling of m and the stretch wait are all checked at their real sizes.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  localparam int DIV_W    = 12;
  localparam int DIV_LO_W = 10;
  localparam int DIV_HI_W = DIV_W - DIV_LO_W;
  localparam int CNT_W    = DIV_W + 2;

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } phase_e;

  typedef struct packed {
    div_t n;
    div_t m;
    logic low_en;
  } div_cfg_t;

  // zero is treated as the smallest count
  function automatic div_t at_least_one(div_t v);
    return (v == '0) ? div_t'(1) : v;
  endfunction

  // full released time of the high phase
  function automatic cnt_t high_total(div_t n, int lat);
    return cnt_t'(at_least_one(n)) + cnt_t'(lat);
  endfunction

  // part of the high phase spent in the counter (the rest is synchroniser and wait)
  function automatic cnt_t high_counted(div_t n, int lat, int sync);
    return high_total(n, lat) - cnt_t'(sync + 1);
  endfunction

  // driven-low time
  function automatic cnt_t low_total(div_cfg_t cfg, int lat);
    if (cfg.low_en)
      return cnt_t'({1'b0, at_least_one(cfg.m), 1'b0});
    return high_total(cfg.n, lat);
  endfunction

endpackage

// File: rtl/scl_field_decode.sv
module scl_field_decode
  import scl_timing_pkg::*;
(
  input  logic [DIV_LO_W-1:0] div_lo_i,
  input  logic [DIV_HI_W-1:0] div_hi_i,
  input  div_t                low_div_i,
  input  logic                low_en_i,
  output div_cfg_t            cfg_o
);

  always_comb begin
    cfg_o.n      = {div_hi_i, div_lo_i};
    cfg_o.m      = low_div_i;
    cfg_o.low_en = low_en_i;
  end

endmodule

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  output logic scl_hi_o
);

  logic [STAGES-1:0] sr;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b1;
          else        sr[0] <= scl_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[k] <= 1'b1;
          else        sr[k] <= sr[k-1];
        end
      end
    end
  endgenerate

  assign scl_hi_o = sr[STAGES-1];

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_timing_pkg::*;
#(
  parameter int FILT_LAT    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_i,
  input  div_cfg_t cfg_i,
  input  logic     scl_hi_i,
  output logic     drive_low_o,
  output logic     tick_fall_o,
  output logic     tick_rise_o,
  output logic     tick_sample_o
);

  phase_e ph;
  cnt_t   cnt;
  cnt_t   half_q;

  // named internal events
  logic phase_done;
  logic start_low;
  logic start_high;
  cnt_t low_load;
  cnt_t high_load;

  assign phase_done = (cnt == '0);
  assign low_load   = low_total(cfg_i, FILT_LAT) - cnt_t'(1);
  assign high_load  = high_counted(cfg_i.n, FILT_LAT, SYNC_STAGES) - cnt_t'(1);
  assign start_low  = ((ph == PH_IDLE) && run_i) ||
                      ((ph == PH_HIGH) && phase_done && run_i);
  assign start_high = (ph == PH_WAIT) && scl_hi_i;

  assign tick_sample_o = (ph == PH_HIGH) && (cnt == half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      cnt         <= '0;
      half_q      <= '0;
      drive_low_o <= 1'b0;
      tick_fall_o <= 1'b0;
      tick_rise_o <= 1'b0;
    end else begin
      tick_fall_o <= 1'b0;
      tick_rise_o <= 1'b0;
      if (start_low) begin
        ph          <= PH_LOW;
        cnt         <= low_load;
        drive_low_o <= 1'b1;
        tick_fall_o <= 1'b1;
      end else begin
        unique case (ph)
          PH_IDLE: ;
          PH_LOW: begin
            if (phase_done) begin
              ph          <= PH_WAIT;
              drive_low_o <= 1'b0;
              tick_rise_o <= 1'b1;
            end else begin
              cnt <= cnt - cnt_t'(1);
            end
          end
          PH_WAIT: begin
            if (start_high) begin
              ph     <= PH_HIGH;
              cnt    <= high_load;
              half_q <= high_load >> 1;
            end
          end
          PH_HIGH: begin
            if (phase_done) ph  <= PH_IDLE;
            else            cnt <= cnt - cnt_t'(1);
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  // R1: idle keeps the line released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> !drive_low_o);

  // R3: the high counter steps down by one each cycle until done
  p_high_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HIGH && !phase_done) |=> (ph == PH_HIGH && cnt == $past(cnt) - cnt_t'(1)));

  // R6: no drive while a released line still reads low
  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_WAIT && !scl_hi_i) |=> !drive_low_o);

  // R8: fall tick marks the first driven cycle
  p_fall_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall_o |-> (drive_low_o && !$past(drive_low_o)));

  // R8: rise tick marks the first released cycle
  p_rise_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise_o |-> (!drive_low_o && $past(drive_low_o)));

  // R9: capture point only while released and seen high
  p_sample_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sample_o |-> (!drive_low_o && scl_hi_i));

  // R8, R9: at most one tick at a time
  p_tick_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_fall_o, tick_rise_o, tick_sample_o}));

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_timing_pkg::*;
#(
  parameter int FILT_LAT    = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic [DIV_LO_W-1:0] ctrl_div_lo_i,
  input  logic [DIV_HI_W-1:0] ctrl_div_hi_i,
  input  logic [DIV_W-1:0]    addr_low_div_i,
  input  logic                addr_low_en_i,
  input  logic                scl_i,
  output logic                scl_drive_low_o,
  output logic                tick_fall_o,
  output logic                tick_rise_o,
  output logic                tick_sample_o
);

  div_cfg_t cfg;
  logic     scl_hi;

  scl_field_decode u_dec (
    .div_lo_i (ctrl_div_lo_i),
    .div_hi_i (ctrl_div_hi_i),
    .low_div_i(addr_low_div_i),
    .low_en_i (addr_low_en_i),
    .cfg_o    (cfg)
  );

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .scl_hi_o(scl_hi)
  );

  scl_phase_ctrl #(.FILT_LAT(FILT_LAT), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run_i),
    .cfg_i        (cfg),
    .scl_hi_i     (scl_hi),
    .drive_low_o  (scl_drive_low_o),
    .tick_fall_o  (tick_fall_o),
    .tick_rise_o  (tick_rise_o),
    .tick_sample_o(tick_sample_o)
  );

endmodule

// File: tb/sim_scl_period_gen.sv
module sim_scl_period_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [9:0]  div_lo = '0;
  logic [1:0]  div_hi = '0;
  logic [11:0] low_div = '0;
  logic        low_en = 1'b0;
  logic        slave_hold = 1'b0;
  logic        drive_low, t_fall, t_rise, t_samp;
  logic        scl_line;

  int checks = 0;
  int errors = 0;
  bit at_fall = 1'b0;

  assign scl_line = !drive_low && !slave_hold;

  always #5 clk = ~clk;

  scl_period_gen u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .ctrl_div_lo_i(div_lo), .ctrl_div_hi_i(div_hi),
    .addr_low_div_i(low_div), .addr_low_en_i(low_en),
    .scl_i(scl_line), .scl_drive_low_o(drive_low),
    .tick_fall_o(t_fall), .tick_rise_o(t_rise), .tick_sample_o(t_samp)
  );

  function automatic int exp_high(int n);
    return ((n == 0) ? 1 : n) + 15;
  endfunction

  function automatic int exp_low(int n, int m, bit en);
    return en ? 2 * ((m == 0) ? 1 : m) : exp_high(n);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_n(input int n);
    div_lo = n[9:0];
    div_hi = n[11:10];
  endtask

  task automatic restart(input int n, input int m, input bit en);
    run = 1'b0;
    slave_hold = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    set_n(n);
    low_div = m[11:0];
    low_en = en;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    at_fall = 1'b0;
    @(negedge clk);
    run = 1'b1;
  endtask

  // one bus period, sampled at falling clock edges
  task automatic measure(input int stretch, input int chg_at, input int chg_n,
                         output int lo, output int ext, output int hi,
                         output int smp, output int edges_ok);
    int guard;
    lo = 0; ext = 0; hi = 0; smp = 0; edges_ok = 1; guard = 0;
    if (!at_fall) begin
      do begin
        @(negedge clk);
        guard++;
      end while (!t_fall && guard < 20000);
    end
    at_fall = 1'b0;
    if (!t_fall) edges_ok = 0;
    if (stretch > 0) slave_hold = 1'b1;
    while (drive_low && guard < 40000) begin
      lo++;
      if (lo > 1 && t_fall) edges_ok = 0;
      if (lo == chg_at) set_n(chg_n);
      @(negedge clk);
      guard++;
    end
    if (!t_rise) edges_ok = 0;
    while (!drive_low && !scl_line && guard < 40000) begin
      ext++;
      if (t_samp) smp++;
      if (ext == stretch) slave_hold = 1'b0;
      @(negedge clk);
      guard++;
    end
    while (!drive_low && guard < 40000) begin
      hi++;
      if (t_samp) smp++;
      if (hi > 1 && t_rise) edges_ok = 0;
      @(negedge clk);
      guard++;
    end
    at_fall = 1'b1;
  endtask

  task automatic check_period(input string tag, input int n, input int m, input bit en);
    int lo, ext, hi, smp, ok;
    measure(0, 0, 0, lo, ext, hi, smp, ok);
    chk({tag, " low length"}, lo, exp_low(n, m, en));
    chk({tag, " stretch cycles"}, ext, 0);
    chk({tag, " high length"}, hi, exp_high(n));
    chk({tag, " R9 sample ticks"}, smp, 1);
    chk({tag, " R8 edge ticks"}, ok, 1);
  endtask

  task automatic t_reset;
    int bad;
    bad = 0;
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (drive_low || t_fall || t_rise || t_samp) bad++;
    end
    rst_n = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (drive_low || t_fall || t_rise || t_samp) bad++;
    end
    chk("R1 quiet in reset and idle", bad, 0);
  endtask

  task automatic t_symmetric;
    restart(5, 9, 1'b0);
    check_period("R3 R4 sym n=5", 5, 9, 1'b0);
    check_period("R3 R4 sym n=5 again", 5, 9, 1'b0);
    restart(37, 0, 1'b0);
    check_period("R3 R4 sym n=37", 37, 0, 1'b0);
  endtask

  task automatic t_asym;
    restart(10, 3, 1'b1);
    check_period("R4 asym n=10 m=3", 10, 3, 1'b1);
    restart(20, 26, 1'b1);
    check_period("R4 duty n=20 m=26", 20, 26, 1'b1);
  endtask

  task automatic t_fields;
    restart(1025, 4, 1'b1);
    check_period("R2 split n=1025", 1025, 4, 1'b1);
    restart(4095, 4095, 1'b1);
    check_period("R2 R4 full scale", 4095, 4095, 1'b1);
  endtask

  task automatic t_zero;
    restart(0, 0, 1'b1);
    check_period("R5 zero n m", 0, 0, 1'b1);
    restart(0, 7, 1'b0);
    check_period("R5 zero n sym", 0, 7, 1'b0);
  endtask

  task automatic t_stretch;
    int lo, ext, hi, smp, ok;
    restart(5, 4, 1'b1);
    measure(7, 0, 0, lo, ext, hi, smp, ok);
    chk("R6 drive length unchanged", lo, exp_low(5, 4, 1'b1));
    chk("R6 stretch seen", ext, 7);
    chk("R6 high after stretch", hi, exp_high(5) - 1);
    chk("R6 R9 sample once", smp, 1);
    check_period("R6 next period normal", 5, 4, 1'b1);
  endtask

  task automatic t_reload;
    int lo, ext, hi, smp, ok;
    restart(5, 0, 1'b0);
    measure(0, 3, 9, lo, ext, hi, smp, ok);
    chk("R7 current low kept", lo, exp_high(5));
    chk("R7 next high new", hi, exp_high(9));
    check_period("R7 later period new", 9, 0, 1'b0);
  endtask

  task automatic t_stop;
    int drv, falls, rises;
    restart(6, 5, 1'b1);
    drv = 0; falls = 0; rises = 0;
    do @(negedge clk); while (!t_fall);
    run = 1'b0;
    drv = 1;
    repeat (200) begin
      @(negedge clk);
      if (drive_low) drv++;
      if (t_fall) falls++;
      if (t_rise) rises++;
    end
    chk("R10 last low completes", drv, exp_low(6, 5, 1'b1));
    chk("R10 no new fall", falls, 0);
    chk("R10 one release", rises, 1);
    chk("R10 released at end", int'(drive_low), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_symmetric();
    t_asym();
    t_fields();
    t_zero();
    t_stretch();
    t_reload();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule